// File: doc/BRIEF.md
# BCD Real-Time Clock Calendar

This block keeps wall-clock time and calendar date in packed BCD: seconds, minutes, hours, date of month, month, day of week and a two-digit year. A built-in prescaler counts pulses of a reference enable, which is nominally 32.768 kHz and derived from the system clock. The prescaler yields one timekeeping tick per second. Each tick advances the seconds, and carries ripple up the chain to minutes, hours, date, month and year in the same clock cycle.

A host reaches the counters through a flat register port. It has a write strobe with address and data, and a separate combinational read address. The hours register runs in either a 24-hour format or a 12-hour format with a PM flag. The date wraps at the right limit for each month, and February follows a leap-year rule. The top bit of the seconds register is a halt flag that freezes the prescaler and all counting until the host clears it.

Top module: `rtc_bcd_core`

## Requirements
- R1: After a synchronous active-low reset the registers read seconds 0x00, minutes 0x00, hours 0x00 (24-hour), date 0x01, month 0x01, day of week 0x01, year 0x00.
- R2: The register addresses are seconds 0, minutes 1, hours 2, date 3, month 4, day of week 5 and year 6. A write loads the byte in the next cycle. Address 7 always reads 0x00, and writes to it are dropped.
- R3: A tick occurs on every PRESCALE-th accepted reference pulse. A host write to addresses 0 to 6 clears the pulse count and suppresses the tick in that cycle, so a full PRESCALE pulses must follow before the next tick.
- R4: Seconds (bits 6:0) and minutes count in BCD from 00 to 59. On a tick, 59 wraps to 00 and advances the next field.
- R5: With hours bit 7 at 0, hours count 00 to 23 in BCD, using bits 5:0. 23 wraps to 00 and advances the date.
- R6: With hours bit 7 at 1, bits 4:0 hold 01 to 12 in BCD and bit 5 is PM. The sequence 11 goes to 12 and toggles PM, and 12 goes to 01 with PM kept. Going from 11 PM to 12 AM advances the date.
- R7: The date wraps to 01 after 28 or 29 in February, after 30 in April, June, September and November, and after 31 otherwise. February has 29 days when the BCD year is a multiple of four, including 00.
- R8: The month counts 01 to 12, and a wrap to 01 advances the year. The year wraps from 99 to 00.
- R9: Day of week counts 1 to 7, wrapping to 1. It advances on exactly the ticks that advance the date.
- R10: While seconds bit 7 is 1, no register changes except by host writes. Writing seconds with bit 7 at 0 resumes counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_en | input | 1 | One-cycle reference pulse (nominal 32.768 kHz rate) |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 3 | Host write address |
| wr_data | input | 8 | Host write data |
| rd_addr | input | 3 | Host read address |
| rd_data | output | 8 | Register selected by rd_addr |

## Verification
The hardest cases to reach are the calendar carries: Feb 28 to 29 in leap and non-leap years, and 11 PM to 12 AM in 12-hour mode. Each one needs a full cascade through seconds, minutes and hours on a single tick. The stimulus table sets every register to one second before the boundary, then applies exactly PRESCALE reference pulses. A single tick then drives the carry through the whole chain. The prescaler restart is reached by sending pulses up to one short of a tick, writing an unrelated register, and showing that the next tick still needs a full count.

// File: rtl/rtc_bcd_pkg.sv
// Shared constants and helpers for the BCD clock calendar.
// Assumes all arithmetic operands are valid packed BCD bytes.
package rtc_bcd_pkg;
    localparam int NUM_TREGS = 7;
    localparam logic [2:0] A_SEC   = 3'd0;
    localparam logic [2:0] A_MIN   = 3'd1;
    localparam logic [2:0] A_HOUR  = 3'd2;
    localparam logic [2:0] A_DATE  = 3'd3;
    localparam logic [2:0] A_MONTH = 3'd4;
    localparam logic [2:0] A_DOW   = 3'd5;
    localparam logic [2:0] A_YEAR  = 3'd6;

    // Add one to a two-digit packed BCD value.
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] >= 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        else
            return {v[7:4], v[3:0] + 4'd1};
    endfunction
endpackage

// File: rtl/rtc_prescaler.sv
// Divides the reference pulse stream down to a one-per-second tick.
// Assumes ref_en is a single-cycle enable; halt freezes the count,
// restart clears it and suppresses a tick in the same cycle.
module rtc_prescaler #(
    parameter int PRESCALE = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_en,
    input  logic halt,
    input  logic restart,
    output logic tick
);
    localparam int CW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);

    logic [CW-1:0] cnt_q;

    // Count accepted reference pulses modulo PRESCALE.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (restart)
            cnt_q <= '0;
        else if (ref_en && !halt)
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    // Tick on the pulse that completes a full count.
    always_comb tick = ref_en && !halt && !restart && (cnt_q == LAST);
endmodule

// File: rtl/rtc_time_chain.sv
// Seconds, minutes and hours counters in packed BCD, 12/24-hour hours.
// Assumes host writes hold valid BCD; a write has priority over a tick.
module rtc_time_chain
    import rtc_bcd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [2:0] wr_sel,
    input  logic [7:0] wr_data,
    output logic [7:0] sec,
    output logic [7:0] min,
    output logic [7:0] hr,
    output logic       day_carry
);
    logic       sec_wrap, min_wrap, hr_wrap;
    logic [7:0] hr_next;

    // Derive wrap conditions and the next hour value for either format.
    always_comb begin
        sec_wrap = sec[6:0] >= 7'h59;
        min_wrap = min >= 8'h59;
        if (hr[7]) begin
            hr_wrap = hr[5] && (hr[4:0] == 5'h11);
            if (hr[4:0] >= 5'h12)
                hr_next = {1'b1, 1'b0, hr[5], 5'h01};
            else if (hr[4:0] == 5'h11)
                hr_next = {1'b1, 1'b0, ~hr[5], 5'h12};
            else
                hr_next = bcd_inc({3'b000, hr[4:0]}) | {1'b1, 1'b0, hr[5], 5'h00};
        end else begin
            hr_wrap = hr[5:0] >= 6'h23;
            hr_next = hr_wrap ? 8'h00 : bcd_inc({2'b00, hr[5:0]});
        end
        day_carry = tick && sec_wrap && min_wrap && hr_wrap;
    end

    // Seconds: keep the halt bit, count the low seven bits.
    always_ff @(posedge clk) begin
        if (!rst_n)         sec <= 8'h00;
        else if (wr_sel[0]) sec <= wr_data;
        else if (tick)      sec <= sec_wrap ? {sec[7], 7'h00} : {sec[7], bcd_inc({1'b0, sec[6:0]})[6:0]};
    end

    // Minutes advance when seconds wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)                 min <= 8'h00;
        else if (wr_sel[1])         min <= wr_data;
        else if (tick && sec_wrap)  min <= min_wrap ? 8'h00 : bcd_inc(min);
    end

    // Hours advance when minutes wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)                            hr <= 8'h00;
        else if (wr_sel[2])                    hr <= wr_data;
        else if (tick && sec_wrap && min_wrap) hr <= hr_next;
    end
endmodule

// File: rtl/rtc_date_chain.sv
// Date, month, day-of-week and year counters in packed BCD.
// Assumes host writes hold valid BCD; leap years are BCD years divisible by 4.
module rtc_date_chain
    import rtc_bcd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       day_carry,
    input  logic [3:0] wr_sel,
    input  logic [7:0] wr_data,
    output logic [7:0] date,
    output logic [7:0] month,
    output logic [7:0] dow,
    output logic [7:0] year
);
    logic       leap, date_wrap, mon_wrap;
    logic [7:0] limit;

    // Month length and leap-year detection.
    always_comb begin
        leap = year[4] ? (year[3:0] == 4'd2 || year[3:0] == 4'd6)
                       : (year[3:0] == 4'd0 || year[3:0] == 4'd4 || year[3:0] == 4'd8);
        case (month)
            8'h02:                      limit = leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: limit = 8'h30;
            default:                    limit = 8'h31;
        endcase
        date_wrap = date >= limit;
        mon_wrap  = month >= 8'h12;
    end

    // Date of month.
    always_ff @(posedge clk) begin
        if (!rst_n)         date <= 8'h01;
        else if (wr_sel[0]) date <= wr_data;
        else if (day_carry) date <= date_wrap ? 8'h01 : bcd_inc(date);
    end

    // Month advances on a date wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)                      month <= 8'h01;
        else if (wr_sel[1])              month <= wr_data;
        else if (day_carry && date_wrap) month <= mon_wrap ? 8'h01 : bcd_inc(month);
    end

    // Day of week advances with every date change.
    always_ff @(posedge clk) begin
        if (!rst_n)         dow <= 8'h01;
        else if (wr_sel[2]) dow <= wr_data;
        else if (day_carry) dow <= (dow[2:0] >= 3'd7) ? 8'h01 : {5'b0, dow[2:0] + 3'd1};
    end

    // Year advances on a month wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  year <= 8'h00;
        else if (wr_sel[3])                          year <= wr_data;
        else if (day_carry && date_wrap && mon_wrap) year <= (year >= 8'h99) ? 8'h00 : bcd_inc(year);
    end
endmodule

// File: rtl/rtc_bcd_core.sv
// Top of the BCD clock calendar: prescaler, time and date chains,
// host write decode and read mux. Seconds bit 7 halts timekeeping.
module rtc_bcd_core
    import rtc_bcd_pkg::*;
#(
    parameter int PRESCALE = 32768
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_en,
    input  logic       wr_en,
    input  logic [2:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [2:0] rd_addr,
    output logic [7:0] rd_data
);
    logic [NUM_TREGS-1:0] wr_sel;
    logic                 restart, tick, day_carry;
    logic [7:0]           sec_q, min_q, hr_q, date_q, month_q, dow_q, year_q;

    // One-hot write select per time register.
    for (genvar g = 0; g < NUM_TREGS; g++) begin : g_wsel
        assign wr_sel[g] = wr_en && (wr_addr == 3'(g));
    end

    // Any time-register write restarts the second.
    always_comb restart = |wr_sel;

    rtc_prescaler #(.PRESCALE(PRESCALE)) u_pre (
        .clk(clk), .rst_n(rst_n), .ref_en(ref_en),
        .halt(sec_q[7]), .restart(restart), .tick(tick)
    );

    rtc_time_chain u_time (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .wr_sel(wr_sel[2:0]), .wr_data(wr_data),
        .sec(sec_q), .min(min_q), .hr(hr_q), .day_carry(day_carry)
    );

    rtc_date_chain u_date (
        .clk(clk), .rst_n(rst_n), .day_carry(day_carry),
        .wr_sel(wr_sel[6:3]), .wr_data(wr_data),
        .date(date_q), .month(month_q), .dow(dow_q), .year(year_q)
    );

    // Host read mux; address 7 is reserved and reads zero.
    always_comb begin
        case (rd_addr)
            A_SEC:   rd_data = sec_q;
            A_MIN:   rd_data = min_q;
            A_HOUR:  rd_data = hr_q;
            A_DATE:  rd_data = date_q;
            A_MONTH: rd_data = month_q;
            A_DOW:   rd_data = dow_q;
            A_YEAR:  rd_data = year_q;
            default: rd_data = 8'h00;
        endcase
    end
endmodule

// File: rtl/rtc_bcd_core_chk.sv
// Assertion checker for rtc_bcd_core, attached by bind below.
// Assumes it observes the internal tick and register outputs.
module rtc_bcd_core_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [2:0] wr_addr,
    input logic       tick,
    input logic [7:0] sec,
    input logic [7:0] min,
    input logic [7:0] hr,
    input logic [7:0] date,
    input logic [7:0] dow
);
    // R3: a time-register write never coincides with a tick.
    p_write_restarts_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != 3'd7) |-> !tick);

    // R10: halted and no write keeps the time fields frozen.
    p_halt_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sec[7] && !wr_en) |=> ($stable(sec) && $stable(min) && $stable(hr)));

    // R4: seconds wrap from 59 to 00.
    p_sec_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && sec[6:0] == 7'h59) |=> (sec[6:0] == 7'h00));

    // R6: 11:59:59 AM in 12-hour mode becomes 12 PM.
    p_noon_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && sec == 8'h59 && min == 8'h59 && hr == 8'h91) |=> (hr == 8'hB2));

    // R9: a date change without a write moves the day of week too.
    p_dow_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(wr_en) && date != $past(date)) |-> (dow != $past(dow)));
endmodule

bind rtc_bcd_core rtc_bcd_core_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .tick(tick),
    .sec(sec_q), .min(min_q), .hr(hr_q), .date(date_q), .dow(dow_q)
);

// File: tb/rtc_bcd_core_bench.sv
module rtc_bcd_core_bench;
    localparam int PRE = 3;
    localparam int NV  = 16;

    // Inputs: sec min hr date month dow year ; outputs after one tick.
    localparam logic [55:0] VIN [NV] = '{
        56'h00_00_00_01_01_01_24, 56'h09_00_00_15_05_02_25,
        56'h59_00_00_15_05_02_25, 56'h59_59_09_15_05_02_25,
        56'h59_59_19_15_05_02_25, 56'h59_59_23_31_12_07_99,
        56'h59_59_23_28_02_03_23, 56'h59_59_23_28_02_03_24,
        56'h59_59_23_29_02_04_24, 56'h59_59_23_30_04_02_25,
        56'h59_59_23_30_05_02_25, 56'h59_59_23_28_02_06_00,
        56'h59_59_91_15_05_02_25, 56'h59_59_B1_15_05_07_25,
        56'h59_59_92_15_05_02_25, 56'h59_59_B2_15_05_02_25};
    localparam logic [55:0] VOUT [NV] = '{
        56'h01_00_00_01_01_01_24, 56'h10_00_00_15_05_02_25,
        56'h00_01_00_15_05_02_25, 56'h00_00_10_15_05_02_25,
        56'h00_00_20_15_05_02_25, 56'h00_00_00_01_01_01_00,
        56'h00_00_00_01_03_04_23, 56'h00_00_00_29_02_04_24,
        56'h00_00_00_01_03_05_24, 56'h00_00_00_01_05_03_25,
        56'h00_00_00_31_05_03_25, 56'h00_00_00_29_02_07_00,
        56'h00_00_B2_15_05_02_25, 56'h00_00_92_16_05_01_25,
        56'h00_00_81_15_05_02_25, 56'h00_00_A1_15_05_02_25};
    string vtag [NV] = '{"R4", "R4", "R4", "R5", "R5", "R8", "R7", "R7",
                         "R7", "R7", "R7", "R7", "R6", "R9", "R6", "R6"};

    logic       clk = 0, rst_n = 0, ref_en = 0, wr_en = 0;
    logic [2:0] wr_addr = '0, rd_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    int total = 0, bad = 0;
    logic [7:0] got;

    rtc_bcd_core #(.PRESCALE(PRE)) u_rtc_bcd_core (
        .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    always #5 clk = ~clk;

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); rd_addr = a; #1 d = rd_data;
    endtask

    task automatic pulse();
        @(negedge clk); ref_en = 1;
        @(negedge clk); ref_en = 0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        // R1 reset values, R2 address 7 reads zero
        rd(0, got); check("R1 sec", got, 8'h00);
        rd(1, got); check("R1 min", got, 8'h00);
        rd(2, got); check("R1 hour", got, 8'h00);
        rd(3, got); check("R1 date", got, 8'h01);
        rd(4, got); check("R1 month", got, 8'h01);
        rd(5, got); check("R1 dow", got, 8'h01);
        rd(6, got); check("R1 year", got, 8'h00);
        rd(7, got); check("R2 reserved", got, 8'h00);

        // Table walk: load, one tick, compare every register
        for (int i = 0; i < NV; i++) begin
            for (int a = 0; a < 7; a++) wr(3'(a), VIN[i][55-8*a -: 8]);
            repeat (PRE) pulse();
            for (int a = 0; a < 7; a++) begin
                rd(3'(a), got);
                check(vtag[i], got, VOUT[i][55-8*a -: 8]);
            end
        end

        // R2: write to address 7 is dropped
        wr(7, 8'hFF);
        rd(7, got); check("R2 addr7 write", got, 8'h00);

        // R10: halt freezes counting, clearing it resumes
        wr(1, 8'h30); wr(0, 8'h85);
        repeat (2 * PRE) pulse();
        rd(0, got); check("R10 halted sec", got, 8'h85);
        rd(1, got); check("R10 halted min", got, 8'h30);
        wr(0, 8'h05);
        repeat (PRE) pulse();
        rd(0, got); check("R10 resumed", got, 8'h06);

        // R3: write mid-count restarts the prescaler
        wr(0, 8'h10);
        repeat (PRE - 1) pulse();
        wr(1, 8'h42);
        repeat (PRE - 1) pulse();
        rd(0, got); check("R3 no early tick", got, 8'h10);
        pulse();
        rd(0, got); check("R3 tick after full count", got, 8'h11);
        rd(1, got); check("R2 min written", got, 8'h42);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule